// File: doc/BRIEF.md
# Factory Bad-Block Marker Scanner

This block classifies a contiguous range of erase blocks of a NAND array as good or factory-marked bad before any other use of the array. For each block it asks a page-read back end for the first element of the spare region of page 0. If that element is all zero the block is bad at once. Otherwise it also asks for the same element of the block's last page. The outcome of each block goes into an internal one-bit-per-block map, and a running total of bad blocks is kept.

The page geometry comes in at run time: data bytes per page, pages per block and the bus width. The spare region starts right after the data bytes, so the element asked for sits at column `data_bytes` on a byte bus and at column `data_bytes/2` on a 16-bit bus. The same rule applies to single-level and multi-level cell parts. The back end is a simple level handshake that returns one element per request. When the scan ends, software or a later block reads the map through an index port.

Top module: `bbm_scan`

## Requirements
- R1: While reset is low and right after it, `done` is 0, `rd_req` is 0, `bad_count` is 0 and every map entry reads 0.
- R2: A `start` pulse while idle clears the whole map and the count, latches the range and the geometry, and scans blocks from `first_block` up to `last_block` in ascending order. `done` goes to 1 after the last block and stays there until the next accepted start. A `start` that arrives during a scan is ignored.
- R3: The first request for each block carries that block index, page 0, and column `data_bytes` when `wide_bus`=0 or `data_bytes>>1` when `wide_bus`=1.
- R4: When the page-0 element is a zero marker, the block is recorded bad and no last-page request is issued for it.
- R5: When the page-0 element is not a zero marker, a second request for page `pages_per_block-1` (same block, same column) follows. The block is bad only if that element is a zero marker, and good otherwise.
- R6: With `wide_bus`=0 only bits [7:0] of `rsp_data` are compared with zero and bits [15:8] have no effect. With `wide_bus`=1 all 16 bits must be zero for a zero marker.
- R7: Once raised, `rd_req` stays high with `rd_block`, `rd_page` and `rd_col` unchanged until a rising edge samples `rsp_valid` high. That edge completes the request.
- R8: `bad_count` equals the number of blocks recorded bad in the current scan, and rises by at most one per cycle.
- R9: `map_bad` shows without delay the flag of block `map_idx`: 1 for bad, 0 for good and for any block outside the last scanned range.
- R10: A start with `last_block` < `first_block` issues no request, leaves the count at 0 and raises `done` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a scan (accepted only while idle) |
| first_block | input | BLK_W | First block of the range |
| last_block | input | BLK_W | Last block of the range |
| data_bytes | input | COL_W | Data bytes per page |
| pages_per_block | input | PG_W | Pages per block (at least 1) |
| wide_bus | input | 1 | 1 for a 16-bit array bus, 0 for 8-bit |
| rd_req | output | 1 | Read request to the page back end |
| rd_block | output | BLK_W | Requested block |
| rd_page | output | PG_W | Requested page within the block |
| rd_col | output | COL_W | Requested column (first spare element) |
| rsp_valid | input | 1 | Back end returns the element |
| rsp_data | input | 16 | Returned spare element |
| map_idx | input | BLK_W | Map read index |
| map_bad | output | 1 | Bad flag of block `map_idx` |
| done | output | 1 | Scan finished |
| bad_count | output | BLK_W+1 | Bad blocks found in the current scan |

## Verification
The back-end model replies after a random delay of zero to three cycles. Its markers are drawn so that some blocks fail on page 0, some fail only on the last page and some pass. This separates the early exit from the two-page check. Some markers have a zero low byte and a nonzero high byte, and are scanned in both bus modes, so that 8-bit and 16-bit comparison can be told apart. Directed scans use a one-page block (page 0 read twice), a single-block range, a reversed range, an all-bad range and a restart issued during a scan. The map is checked just outside each range, so a missing clear from the previous scan would show.

// File: rtl/bbm_pkg.sv
// Shared types of the bad-block scanner.
package bbm_pkg;
    // Scan sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIRST = 2'd1,
        ST_LAST  = 2'd2
    } scan_st_t;
endpackage

// File: rtl/bbm_marker_chk.sv
// Decides whether one returned spare element is a factory bad marker.
// Assumes a 16-bit element bus; in byte mode only the low byte is valid.
module bbm_marker_chk #(
    parameter int ELEM_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic              wide,
    input  logic [ELEM_W-1:0] elem,
    output logic              is_zero
);
    // Compare the full element or just its low byte with zero.
    always_comb begin
        if (wide) is_zero = (elem == '0);
        else      is_zero = (elem[BYTE_W-1:0] == '0);
    end
endmodule

// File: rtl/bbm_bitmap.sv
// One flag per block: bulk clear, single-entry write, indexed read.
// Assumes clear and write are never requested together.
module bbm_bitmap #(
    parameter int BLK_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [BLK_W-1:0] wr_idx,
    input  logic             wr_bad,
    input  logic [BLK_W-1:0] rd_idx,
    output logic             rd_bad
);
    localparam int NBLK = 1 << BLK_W;

    logic [NBLK-1:0] flags;

    // Flag storage: reset and clear zero every entry, a write sets one.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) flags <= '0;
        else if (wr_en)    flags[wr_idx] <= wr_bad;
    end

    // Indexed read of a flag, no delay.
    always_comb rd_bad = flags[rd_idx];

    // R2: the cycle after a clear, no entry reads bad.
    a_r2_map_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !rd_bad);
endmodule

// File: rtl/bbm_seq.sv
// Scan sequencer: walks the block range, issues page-0 and last-page
// requests, decides each block and counts bad ones.
// Assumes geometry inputs are valid at start and pages_per_block >= 1.
module bbm_seq
    import bbm_pkg::*;
#(
    parameter int BLK_W = 10,
    parameter int PG_W  = 9,
    parameter int COL_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [BLK_W-1:0] first_block,
    input  logic [BLK_W-1:0] last_block,
    input  logic [COL_W-1:0] data_bytes,
    input  logic [PG_W-1:0]  pages_per_block,
    input  logic             wide_bus,
    input  logic             rsp_valid,
    input  logic             mark_zero,
    output logic             cfg_wide,
    output logic             rd_req,
    output logic [BLK_W-1:0] rd_block,
    output logic [PG_W-1:0]  rd_page,
    output logic [COL_W-1:0] rd_col,
    output logic             bm_clr,
    output logic             bm_wr,
    output logic             bm_bad,
    output logic             done,
    output logic [BLK_W:0]   bad_count
);
    scan_st_t         st;
    logic [BLK_W-1:0] cur_q, end_q;
    logic [PG_W-1:0]  lastpg_q;
    logic [COL_W-1:0] col_q;
    logic             wide_q, done_q;
    logic [BLK_W:0]   cnt_q;
    logic             accept;

    // A start is taken only while idle.
    always_comb accept = (st == ST_IDLE) && start;

    // Sequencer state, range, latched geometry, count and done flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            cur_q    <= '0;
            end_q    <= '0;
            lastpg_q <= '0;
            col_q    <= '0;
            wide_q   <= 1'b0;
            done_q   <= 1'b0;
            cnt_q    <= '0;
        end else if (accept) begin
            cnt_q    <= '0;
            cur_q    <= first_block;
            end_q    <= last_block;
            lastpg_q <= pages_per_block - PG_W'(1);
            col_q    <= wide_bus ? {1'b0, data_bytes[COL_W-1:1]} : data_bytes;
            wide_q   <= wide_bus;
            if (last_block < first_block) begin
                done_q <= 1'b1;
            end else begin
                done_q <= 1'b0;
                st     <= ST_FIRST;
            end
        end else if (st != ST_IDLE && rsp_valid) begin
            if (mark_zero) cnt_q <= cnt_q + (BLK_W+1)'(1);
            if (st == ST_FIRST && !mark_zero) begin
                st <= ST_LAST;
            end else if (cur_q == end_q) begin
                st     <= ST_IDLE;
                done_q <= 1'b1;
            end else begin
                cur_q <= cur_q + BLK_W'(1);
                st    <= ST_FIRST;
            end
        end
    end

    // Request and map-write outputs derived from the state.
    always_comb begin
        rd_req    = (st != ST_IDLE);
        rd_block  = cur_q;
        rd_page   = (st == ST_LAST) ? lastpg_q : '0;
        rd_col    = col_q;
        bm_clr    = accept;
        bm_wr     = rsp_valid && ((st == ST_LAST) || (st == ST_FIRST && mark_zero));
        bm_bad    = mark_zero;
        done      = done_q;
        bad_count = cnt_q;
        cfg_wide  = wide_q;
    end

    // R7: an open request holds its address until answered.
    a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rsp_valid) |=> (rd_req && $stable(rd_block)
                                    && $stable(rd_page) && $stable(rd_col)));

    // R2: a finished scan issues no request.
    a_r2_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !rd_req);

    // R8: the bad count never jumps by more than one during a scan.
    a_r8_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE) |=> (bad_count == $past(bad_count)
                             || bad_count == $past(bad_count) + (BLK_W+1)'(1)));
endmodule

// File: rtl/bbm_scan.sv
// Top of the factory bad-block scanner: sequencer, marker decode and
// per-block flag map. Assumes the back end answers every request.
module bbm_scan #(
    parameter int BLK_W  = 10,
    parameter int PG_W   = 9,
    parameter int COL_W  = 16,
    parameter int ELEM_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BLK_W-1:0]  first_block,
    input  logic [BLK_W-1:0]  last_block,
    input  logic [COL_W-1:0]  data_bytes,
    input  logic [PG_W-1:0]   pages_per_block,
    input  logic              wide_bus,
    output logic              rd_req,
    output logic [BLK_W-1:0]  rd_block,
    output logic [PG_W-1:0]   rd_page,
    output logic [COL_W-1:0]  rd_col,
    input  logic              rsp_valid,
    input  logic [ELEM_W-1:0] rsp_data,
    input  logic [BLK_W-1:0]  map_idx,
    output logic              map_bad,
    output logic              done,
    output logic [BLK_W:0]    bad_count
);
    logic cfg_wide, mark_zero, bm_clr, bm_wr, bm_bad;
    logic [BLK_W-1:0] blk_w;

    always_comb rd_block = blk_w;

    bbm_marker_chk #(.ELEM_W(ELEM_W)) u_mark (
        .wide    (cfg_wide),
        .elem    (rsp_data),
        .is_zero (mark_zero)
    );

    bbm_seq #(.BLK_W(BLK_W), .PG_W(PG_W), .COL_W(COL_W)) u_seq (
        .clk             (clk),
        .rst_n           (rst_n),
        .start           (start),
        .first_block     (first_block),
        .last_block      (last_block),
        .data_bytes      (data_bytes),
        .pages_per_block (pages_per_block),
        .wide_bus        (wide_bus),
        .rsp_valid       (rsp_valid),
        .mark_zero       (mark_zero),
        .cfg_wide        (cfg_wide),
        .rd_req          (rd_req),
        .rd_block        (blk_w),
        .rd_page         (rd_page),
        .rd_col          (rd_col),
        .bm_clr          (bm_clr),
        .bm_wr           (bm_wr),
        .bm_bad          (bm_bad),
        .done            (done),
        .bad_count       (bad_count)
    );

    bbm_bitmap #(.BLK_W(BLK_W)) u_map (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (bm_clr),
        .wr_en  (bm_wr),
        .wr_idx (blk_w),
        .wr_bad (bm_bad),
        .rd_idx (map_idx),
        .rd_bad (map_bad)
    );
endmodule

// File: tb/tb_bbm_scan.sv
module tb_bbm_scan;
    localparam int CLK_PERIOD = 10;
    localparam int BLK_W = 10;
    localparam int PG_W  = 9;
    localparam int COL_W = 16;
    localparam int NMK   = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [BLK_W-1:0] first_block = '0, last_block = '0, map_idx = '0;
    logic [COL_W-1:0] data_bytes = '0;
    logic [PG_W-1:0]  pages_per_block = 9'd1;
    logic wide_bus = 1'b0;
    logic rd_req, map_bad, done;
    logic [BLK_W-1:0] rd_block;
    logic [PG_W-1:0]  rd_page;
    logic [COL_W-1:0] rd_col;
    logic rsp_valid = 1'b0;
    logic [15:0] rsp_data = '0;
    logic [BLK_W:0] bad_count;

    int n_chk = 0, n_bad = 0, cyc = 0;
    logic [15:0] mk0 [NMK];
    logic [15:0] mkl [NMK];
    bit cfg_wide; int cfg_ppb, cfg_db;
    int exp_blk; bit exp_ph; int n_rsp; int lat;
    bit armed = 1'b0;

    bbm_scan #(.BLK_W(BLK_W), .PG_W(PG_W), .COL_W(COL_W)) dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit zmark(input logic [15:0] v, input bit w);
        return w ? (v == 16'h0) : (v[7:0] == 8'h0);
    endfunction

    function automatic bit exp_bad(input int b);
        return zmark(mk0[b], cfg_wide) || zmark(mkl[b], cfg_wide);
    endfunction

    function automatic logic [15:0] rnd_mark();
        int r = $urandom % 8;
        logic [15:0] v;
        if (r == 0) v = 16'h0000;
        else if (r == 1) v = {8'(($urandom % 255) + 1), 8'h00};
        else begin
            v = 16'($urandom);
            if (v[7:0] == 8'h0) v[0] = 1'b1;
        end
        return v;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    // Back-end model: answers after a random delay, checks each request.
    always @(negedge clk) begin
        if (rsp_valid) rsp_valid = 1'b0;
        else if (rd_req && armed) begin
            if (lat == 0) begin
                chk(rd_block == BLK_W'(exp_blk), "R3 block", int'(rd_block), exp_blk);
                chk(rd_page == (exp_ph ? PG_W'(cfg_ppb - 1) : '0), "R4/R5 page",
                    int'(rd_page), exp_ph ? cfg_ppb - 1 : 0);
                chk(rd_col == COL_W'(cfg_wide ? cfg_db / 2 : cfg_db), "R3 column",
                    int'(rd_col), cfg_wide ? cfg_db / 2 : cfg_db);
                rsp_data = exp_ph ? mkl[exp_blk] : mk0[exp_blk];
                rsp_valid = 1'b1;
                n_rsp++;
                if (!exp_ph && !zmark(mk0[exp_blk], cfg_wide)) exp_ph = 1'b1;
                else begin exp_ph = 1'b0; exp_blk++; end
                lat = $urandom % 4;
            end else lat--;
        end
    end

    task automatic scan(input int f, input int l, input int ppb, input int db,
                        input bit w, input bit restart);
        int exp_cnt = 0, exp_rsp = 0;
        @(negedge clk);
        first_block = BLK_W'(f); last_block = BLK_W'(l);
        pages_per_block = PG_W'(ppb); data_bytes = COL_W'(db); wide_bus = w;
        cfg_wide = w; cfg_ppb = ppb; cfg_db = db;
        exp_blk = f; exp_ph = 1'b0; n_rsp = 0; lat = $urandom % 4; armed = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (restart) begin
            repeat (3) @(negedge clk);
            first_block = BLK_W'(f + 2); wide_bus = ~w; pages_per_block = 9'd3;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        for (int b = f; b <= l; b++) begin
            if (exp_bad(b)) exp_cnt++;
            exp_rsp += zmark(mk0[b], w) ? 1 : 2;
        end
        chk(int'(bad_count) == exp_cnt, "R8 bad_count", int'(bad_count), exp_cnt);
        chk(n_rsp == exp_rsp, "R4/R10 request count", n_rsp, exp_rsp);
        for (int b = f - 3; b <= l + 3; b++) begin
            if (b >= 0 && b < NMK) begin
                bit e = (b >= f && b <= l) ? exp_bad(b) : 1'b0;
                map_idx = BLK_W'(b);
                #1;
                chk(map_bad == e, "R9/R5 map flag", int'(map_bad), int'(e));
            end
        end
        chk(done == 1'b1 && rd_req == 1'b0, "R2 done held", int'(done), 1);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_bad++;
                $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd2718));
        for (int i = 0; i < NMK; i++) begin mk0[i] = 16'hFFFF; mkl[i] = 16'hFFFF; end
        repeat (3) @(negedge clk);
        map_idx = BLK_W'(5);
        #1;
        // R1: reset state
        chk(done == 1'b0 && rd_req == 1'b0, "R1 reset outputs", int'(done), 0);
        chk(bad_count == '0 && map_bad == 1'b0, "R1 reset count/map", int'(bad_count), 0);
        rst_n = 1'b1;

        // R5: all good, two requests each
        scan(0, 7, 64, 2048, 1'b0, 1'b0);
        // R6: 0x0100 is bad on a byte bus, good on a word bus
        mk0[10] = 16'h0100; mkl[11] = 16'h0100; mk0[12] = 16'h0000;
        scan(9, 13, 128, 4096, 1'b0, 1'b0);
        scan(9, 13, 128, 4096, 1'b1, 1'b0);
        // R5: one-page block reads page 0 twice
        mkl[20] = 16'h0000;
        scan(18, 22, 1, 512, 1'b0, 1'b0);
        // single-block range
        scan(20, 20, 1, 512, 1'b1, 1'b0);
        // R10: reversed range
        scan(30, 25, 64, 2048, 1'b0, 1'b0);
        chk(bad_count == '0, "R10 empty count", int'(bad_count), 0);
        // R4: all bad on page 0
        for (int i = 40; i < 50; i++) mk0[i] = 16'h0000;
        scan(40, 49, 256, 8192, 1'b1, 1'b0);
        // R2: restart during a scan is ignored
        for (int i = 0; i < NMK; i++) begin mk0[i] = rnd_mark(); mkl[i] = rnd_mark(); end
        scan(2, 20, 64, 2048, 1'b0, 1'b1);
        // random scans
        for (int t = 0; t < 14; t++) begin
            int f = $urandom % 50;
            int l = f + ($urandom % 14);
            for (int i = 0; i < NMK; i++) begin mk0[i] = rnd_mark(); mkl[i] = rnd_mark(); end
            scan(f, l, ($urandom % 300) + 1, 512 * (($urandom % 16) + 1), 1'($urandom % 2), 1'b0);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule